// File: doc/BRIEF.md
# UART Character-Level Loopback and Modem-Line Mirror

This block sits between a UART's register file, its receive buffer and its receiver. While the loopback-enable control bit is clear it is transparent: characters from the external receiver pass straight to the receive buffer push port, and the four modem-status flags follow the external modem input pins through a synchroniser. When loopback is enabled, the block turns the UART back on itself at character level. Every transmit-data write is pushed into the receive buffer. A rising send-break bit pushes a break marker. Characters from the external receiver are accepted and thrown away. The four software-driven modem-control outputs are copied onto the modem-status flags through a fixed cross-mapping.

Each control-register write made while loopback is enabled also rebuilds the four modem-status interrupt bits from the mirrored flags. All four are replaced at once, so a flag that is low clears its interrupt bit. The write that first sets loopback-enable counts as such a write. The receive push port follows valid/ready rules. The external path is truly back-pressured: `ext_ready` equals `rxq_ready` outside loopback. A loopback source cannot be stalled. A loopback push offered while `rxq_ready` is low is lost, and `rxq_ovr` is raised in the same cycle. Hardware flow control of the modem lines is not handled here.

Top module: `uart_loopback_mirror`

## Requirements
- R1: With `ctl_lpbk` high, a cycle with `ctl_wr` high makes the flags, on the next cycle, equal to the mapping ring-indicator = `ctl_out2`, carrier-detect = `ctl_out1`, clear-to-send = `ctl_rts`, data-set-ready = `ctl_dtr`.
- R2: The mirror is applied by every control write with `ctl_lpbk` high, including the write that first sets it. Between such writes the flags hold their value, and the modem pins have no effect.
- R3: On the cycle after a control write with `ctl_lpbk` high, `ms_upd` is high for one cycle. `ms_val` carries all four modem interrupt bits, each equal to its mirrored flag: bit 0 ring-indicator, bit 1 clear-to-send, bit 2 carrier-detect, bit 3 data-set-ready.
- R4: With `ctl_lpbk` high, a cycle with `tx_valid` high drives `rxq_valid` high in the same cycle. `rxq_data` then holds `tx_data` zero-extended, with the break bit (bit 10) clear.
- R5: With `ctl_lpbk` high, `ext_ready` is high and external characters are never forwarded to the receive port.
- R6: With `ctl_lpbk` high, a 0-to-1 change of `brk_ctl` pushes an entry whose only set bit is bit 10. A held or falling `brk_ctl` pushes nothing, and a rise while loopback is off pushes nothing.
- R7: If a break rise and a transmit write fall in the same cycle, the character is pushed first. The break entry follows in the next cycle without `tx_valid`.
- R8: With `ctl_lpbk` low, the flags follow `pin_ri`, `pin_dcd`, `pin_cts` and `pin_dsr` three rising edges after a pin change, and `ms_upd` stays low.
- R9: A loopback push offered while `rxq_ready` is low is dropped, and `rxq_ovr` is high in that cycle. `rxq_ovr` is never high outside loopback.
- R10: With `ctl_lpbk` low, `rxq_valid`, `rxq_data` and `ext_ready` follow `ext_valid`, `ext_data` and `rxq_ready`, and transmit writes push nothing.
- R11: During and right after reset, the flags are zero and `ms_upd` and `rxq_valid` are low while the inputs are idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control register was written; the fields below already hold the new value |
| ctl_lpbk | input | 1 | Loopback enable field |
| ctl_out2 | input | 1 | Software output 2 field |
| ctl_out1 | input | 1 | Software output 1 field |
| ctl_rts | input | 1 | Request-to-send field |
| ctl_dtr | input | 1 | Data-terminal-ready field |
| brk_ctl | input | 1 | Send-break control bit (level) |
| tx_valid | input | 1 | Transmit-data write strobe |
| tx_data | input | DATA_W | Written transmit character |
| ext_valid | input | 1 | External receiver has a character |
| ext_ready | output | 1 | External character accepted |
| ext_data | input | BRK_POS+1 | External receive entry |
| rxq_valid | output | 1 | Push into the receive buffer |
| rxq_ready | input | 1 | Receive buffer has room |
| rxq_data | output | BRK_POS+1 | Entry pushed; bit BRK_POS marks a break |
| rxq_ovr | output | 1 | Loopback push lost on a full buffer |
| pin_ri | input | 1 | External ring-indicator pin (asynchronous) |
| pin_dcd | input | 1 | External carrier-detect pin (asynchronous) |
| pin_cts | input | 1 | External clear-to-send pin (asynchronous) |
| pin_dsr | input | 1 | External data-set-ready pin (asynchronous) |
| flg_ri | output | 1 | Ring-indicator status flag |
| flg_dcd | output | 1 | Carrier-detect status flag |
| flg_cts | output | 1 | Clear-to-send status flag |
| flg_dsr | output | 1 | Data-set-ready status flag |
| ms_upd | output | 1 | Replace the modem interrupt bits with ms_val |
| ms_val | output | 4 | New modem interrupt bits (RI, CTS, DCD, DSR from bit 0) |

## Verification
The assertions check on every cycle the rules that relate one cycle to the next. They cover the cross-mapping of a loopback control write onto the flags, the holding of the flags between writes, the agreement of `ms_val` with the flags, the same-cycle transmit push, the always-ready external path in loopback, the absence of interrupt updates outside loopback, and the overrun condition. Other behaviours can only be shown by the bench's scenarios. These are the three-edge latency of the pin synchroniser, the ordering of a break behind a transmit write, the absence of a push for held or non-loopback breaks, and the sweep of all sixteen modem patterns and all 256 characters.

// File: rtl/uart_lb_pkg.sv
package uart_lb_pkg;

  localparam int MS_W = 4;

  // bit 0 ring, bit 1 clear-to-send, bit 2 carrier, bit 3 set-ready
  typedef struct packed {
    logic dsr;
    logic dcd;
    logic cts;
    logic ri;
  } mdm_t;

  function automatic mdm_t mirror_map(input logic out2, input logic out1,
                                      input logic rts, input logic dtr);
    mdm_t m;
    m.ri  = out2;
    m.dcd = out1;
    m.cts = rts;
    m.dsr = dtr;
    return m;
  endfunction

endpackage

// File: rtl/lb_sync.sv
module lb_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= '0;
    end else begin
      st[0] <= din;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign dout = st[STAGES-1];
endmodule

// File: rtl/lb_mirror.sv
module lb_mirror
  import uart_lb_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctl_wr,
  input  logic            ctl_lpbk,
  input  logic            ctl_out2,
  input  logic            ctl_out1,
  input  logic            ctl_rts,
  input  logic            ctl_dtr,
  input  mdm_t            pins_s,
  output mdm_t            flags,
  output logic            ms_upd,
  output logic [MS_W-1:0] ms_val
);
  mdm_t mir;
  logic apply;

  assign mir   = mirror_map(ctl_out2, ctl_out1, ctl_rts, ctl_dtr);
  assign apply = ctl_wr & ctl_lpbk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags  <= '0;
      ms_upd <= 1'b0;
      ms_val <= '0;
    end else begin
      ms_upd <= apply;
      if (apply) begin
        flags  <= mir;
        ms_val <= mir;
      end else if (!ctl_lpbk) begin
        flags <= pins_s;
      end
    end
  end

  p_map_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_lpbk) |=> (flags.ri == $past(ctl_out2)) && (flags.dcd == $past(ctl_out1))
                          && (flags.cts == $past(ctl_rts)) && (flags.dsr == $past(ctl_dtr)));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_lpbk && !ctl_wr) |=> (flags == $past(flags)));

  p_ms_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ms_upd |-> (ms_val == flags));

  p_no_ms_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_lpbk |=> !ms_upd);
endmodule

// File: rtl/lb_rxmerge.sv
module lb_rxmerge #(
  parameter int DATA_W  = 8,
  parameter int BRK_POS = 10,
  localparam int ENTRY_W = BRK_POS + 1,
  localparam int PAD_W   = ENTRY_W - DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lpbk,
  input  logic               tx_valid,
  input  logic [DATA_W-1:0]  tx_data,
  input  logic               brk_ctl,
  input  logic               ext_valid,
  output logic               ext_ready,
  input  logic [ENTRY_W-1:0] ext_data,
  output logic               rxq_valid,
  input  logic               rxq_ready,
  output logic [ENTRY_W-1:0] rxq_data,
  output logic               ovr
);
  logic brk_q, pend_q, rise, lb_tx, lb_brk, lb_push;
  logic [ENTRY_W-1:0] brk_word, tx_word;

  assign rise    = brk_ctl & ~brk_q;
  assign lb_tx   = lpbk & tx_valid;
  assign lb_brk  = lpbk & ~tx_valid & (rise | pend_q);
  assign lb_push = lb_tx | lb_brk;
  assign tx_word = {{PAD_W{1'b0}}, tx_data};

  always_comb begin
    brk_word = '0;
    brk_word[BRK_POS] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      brk_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      brk_q <= brk_ctl;
      if (!lpbk)         pend_q <= 1'b0;
      else if (tx_valid) pend_q <= pend_q | rise;
      else               pend_q <= 1'b0;
    end
  end

  always_comb begin
    if (lpbk) begin
      rxq_valid = lb_push;
      rxq_data  = lb_tx ? tx_word : brk_word;
      ext_ready = 1'b1;
    end else begin
      rxq_valid = ext_valid;
      rxq_data  = ext_data;
      ext_ready = rxq_ready;
    end
  end

  assign ovr = lb_push & ~rxq_ready;

  p_tx_push_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lpbk && tx_valid) |-> rxq_valid && (rxq_data[DATA_W-1:0] == tx_data) && !rxq_data[BRK_POS]);

  p_ext_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lpbk |-> ext_ready);

  p_brk_defer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lpbk && tx_valid && rise) |=> (!lpbk || tx_valid || (rxq_valid && rxq_data[BRK_POS])));

  p_ovr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |-> (lpbk && rxq_valid && !rxq_ready));
endmodule

// File: rtl/uart_loopback_mirror.sv
module uart_loopback_mirror
  import uart_lb_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int BRK_POS     = 10,
  parameter int SYNC_STAGES = 2,
  localparam int ENTRY_W = BRK_POS + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_wr,
  input  logic               ctl_lpbk,
  input  logic               ctl_out2,
  input  logic               ctl_out1,
  input  logic               ctl_rts,
  input  logic               ctl_dtr,
  input  logic               brk_ctl,
  input  logic               tx_valid,
  input  logic [DATA_W-1:0]  tx_data,
  input  logic               ext_valid,
  output logic               ext_ready,
  input  logic [ENTRY_W-1:0] ext_data,
  output logic               rxq_valid,
  input  logic               rxq_ready,
  output logic [ENTRY_W-1:0] rxq_data,
  output logic               rxq_ovr,
  input  logic               pin_ri,
  input  logic               pin_dcd,
  input  logic               pin_cts,
  input  logic               pin_dsr,
  output logic               flg_ri,
  output logic               flg_dcd,
  output logic               flg_cts,
  output logic               flg_dsr,
  output logic               ms_upd,
  output logic [MS_W-1:0]    ms_val
);
  mdm_t pins_raw, pins_s, flags;

  assign pins_raw = '{dsr: pin_dsr, dcd: pin_dcd, cts: pin_cts, ri: pin_ri};

  lb_sync #(.W(MS_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .din (pins_raw),
    .dout (pins_s)
  );

  lb_mirror u_mirror (
    .clk (clk),
    .rst_n (rst_n),
    .ctl_wr (ctl_wr),
    .ctl_lpbk (ctl_lpbk),
    .ctl_out2 (ctl_out2),
    .ctl_out1 (ctl_out1),
    .ctl_rts (ctl_rts),
    .ctl_dtr (ctl_dtr),
    .pins_s (pins_s),
    .flags (flags),
    .ms_upd (ms_upd),
    .ms_val (ms_val)
  );

  lb_rxmerge #(.DATA_W(DATA_W), .BRK_POS(BRK_POS)) u_merge (
    .clk (clk),
    .rst_n (rst_n),
    .lpbk (ctl_lpbk),
    .tx_valid (tx_valid),
    .tx_data (tx_data),
    .brk_ctl (brk_ctl),
    .ext_valid (ext_valid),
    .ext_ready (ext_ready),
    .ext_data (ext_data),
    .rxq_valid (rxq_valid),
    .rxq_ready (rxq_ready),
    .rxq_data (rxq_data),
    .ovr (rxq_ovr)
  );

  assign flg_ri  = flags.ri;
  assign flg_dcd = flags.dcd;
  assign flg_cts = flags.cts;
  assign flg_dsr = flags.dsr;
endmodule

// File: tb/sim_uart_loopback_mirror.sv
module sim_uart_loopback_mirror;
  localparam int DW = 8;
  localparam int BP = 10;
  localparam int EW = BP + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_wr = 0, ctl_lpbk = 0, ctl_out2 = 0, ctl_out1 = 0, ctl_rts = 0, ctl_dtr = 0;
  logic brk_ctl = 0, tx_valid = 0, ext_valid = 0, rxq_ready = 1;
  logic [DW-1:0] tx_data = '0;
  logic [EW-1:0] ext_data = '0;
  logic pin_ri = 0, pin_dcd = 0, pin_cts = 0, pin_dsr = 0;
  logic ext_ready, rxq_valid, rxq_ovr, flg_ri, flg_dcd, flg_cts, flg_dsr, ms_upd;
  logic [EW-1:0] rxq_data;
  logic [3:0] ms_val;
  int nvec = 0, nerr = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_loopback_mirror u0 (.*);

  task automatic cmp(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int flg4();
    return {flg_dsr, flg_dcd, flg_cts, flg_ri};
  endfunction

  task automatic ctlw(input logic lp, input logic [3:0] v);
    @(negedge clk);
    ctl_lpbk = lp; ctl_out2 = v[0]; ctl_out1 = v[1]; ctl_rts = v[2]; ctl_dtr = v[3];
    ctl_wr = 1;
    @(negedge clk);
    ctl_wr = 0;
  endtask

  task automatic pins(input logic [3:0] p);
    pin_ri = p[0]; pin_cts = p[1]; pin_dcd = p[2]; pin_dsr = p[3];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++; nvec++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    cmp("R11 flags", flg4(), 0);
    cmp("R11 ms_upd", ms_upd, 0);
    cmp("R11 rxq_valid", rxq_valid, 0);
    rst_n = 1;
    @(negedge clk);
    cmp("R11 flags after release", flg4(), 0);

    // R8: exact synchroniser latency, then sweep all pin patterns
    pins(4'b1011);
    @(negedge clk); @(negedge clk);
    cmp("R8 two edges", flg4(), 0);
    @(negedge clk);
    cmp("R8 three edges", flg4(), 4'b1011);
    for (int p = 0; p < 16; p++) begin
      pins(p[3:0]);
      repeat (4) begin
        @(negedge clk);
        cmp("R8 no ms_upd", ms_upd, 0);
      end
      cmp("R8 follow pins", flg4(), p);
    end

    // R1 R2 R3: entering write mirrors; sweep all control patterns
    pins(4'b0000);
    repeat (4) @(negedge clk);
    ctlw(1'b1, 4'b1111);
    cmp("R2 enabling write", flg4(), 4'hF);
    cmp("R3 enabling ms_upd", ms_upd, 1);
    for (int v = 0; v < 16; v++) begin
      int exp_ms;
      exp_ms = {v[3], v[1], v[2], v[0]};
      pins(~exp_ms[3:0]);
      ctlw(1'b1, v[3:0]);
      cmp("R1 mirror flags", flg4(), exp_ms);
      cmp("R3 ms_upd", ms_upd, 1);
      cmp("R3 ms_val", ms_val, exp_ms);
      repeat (4) @(negedge clk);
      cmp("R3 single pulse", ms_upd, 0);
      cmp("R2 hold vs pins", flg4(), exp_ms);
    end

    // R4: all characters pushed in loopback
    for (int d = 0; d < 256; d++) begin
      @(negedge clk);
      tx_valid = 1; tx_data = d[7:0];
      #1;
      cmp("R4 push valid", rxq_valid, 1);
      cmp("R4 push data", rxq_data, d);
    end
    @(negedge clk); tx_valid = 0;

    // R5: external data discarded
    for (int e = 0; e < 8; e++) begin
      @(negedge clk);
      ext_valid = 1; ext_data = EW'(e * 37 + 5); rxq_ready = e[0];
      #1;
      cmp("R5 ext_ready", ext_ready, 1);
      cmp("R5 not forwarded", rxq_valid, 0);
    end
    @(negedge clk); ext_valid = 0; rxq_ready = 1;

    // R6: break rise, hold, fall
    @(negedge clk); brk_ctl = 1; #1;
    cmp("R6 break valid", rxq_valid, 1);
    cmp("R6 break entry", rxq_data, 1 << BP);
    @(negedge clk); #1;
    cmp("R6 held break", rxq_valid, 0);
    @(negedge clk); brk_ctl = 0; #1;
    cmp("R6 falling break", rxq_valid, 0);

    // R7: simultaneous write and break rise
    @(negedge clk); brk_ctl = 1; tx_valid = 1; tx_data = 8'hA5; #1;
    cmp("R7 char first", rxq_data, 8'hA5);
    @(negedge clk); tx_valid = 0; #1;
    cmp("R7 break next valid", rxq_valid, 1);
    cmp("R7 break next data", rxq_data, 1 << BP);
    @(negedge clk); brk_ctl = 0; #1;
    cmp("R7 no repeat", rxq_valid, 0);

    // R9: overrun on full buffer
    @(negedge clk); rxq_ready = 0; tx_valid = 1; tx_data = 8'h3C; #1;
    cmp("R9 overrun", rxq_ovr, 1);
    @(negedge clk); rxq_ready = 1; #1;
    cmp("R9 no overrun when ready", rxq_ovr, 0);
    @(negedge clk); tx_valid = 0;

    // R10: leave loopback
    ctlw(1'b0, 4'b0000);
    @(negedge clk); tx_valid = 1; tx_data = 8'h77; #1;
    cmp("R10 tx ignored", rxq_valid, 0);
    @(negedge clk); tx_valid = 0; brk_ctl = 1; #1;
    cmp("R6 break off loopback", rxq_valid, 0);
    @(negedge clk); brk_ctl = 0;
    for (int e = 0; e < 4; e++) begin
      @(negedge clk);
      ext_valid = 1; ext_data = EW'(e * 300 + 1); rxq_ready = e[0];
      #1;
      cmp("R10 valid pass", rxq_valid, 1);
      cmp("R10 data pass", rxq_data, e * 300 + 1);
      cmp("R10 ready pass", ext_ready, e[0]);
      cmp("R9 no overrun off loopback", rxq_ovr, 0);
    end
    @(negedge clk); ext_valid = 0; rxq_ready = 1;

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule